// File: doc/BRIEF.md
# Aliased Floating-Point / Vector Register File

This block holds thirty-two architectural registers. Each one is 256 bits wide. The storage is a single array, and it is presented through three nested views:

- a 64-bit scalar view, which covers bits [63:0] of an entry;
- a 128-bit vector view, which covers bits [127:0] of the same entry;
- the full 256-bit vector view.

Because the views alias one another, a value written through any one of them is seen at once by the other two at the same index.

The block has one write port and two read ports. Each port carries a 5-bit register index and a 2-bit view code: `00` selects the 64-bit view, `01` the 128-bit view and `10` the 256-bit view. A write changes only the bits its view covers. Reads are combinational and write-first: if a read index matches a legal write in the same cycle, the read returns the entry with that write already merged in. Read data is zero-extended to 256 bits. An execution pipeline uses the block as its operand store. Arithmetic, exceptions and renaming sit outside it.

Top module: `vrf_alias_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, every entry reads as all zeros in every view until it is written.
- R2: A write with view `10` replaces all 256 bits of the entry, and a later 256-bit read returns exactly that data.
- R3: A write with view `01` replaces bits [127:0] of the entry and leaves bits [255:128] as they were.
- R4: A write with view `00` replaces bits [63:0] of the entry and leaves bits [255:64] as they were.
- R5: A read with view `01` returns bits [127:0] of the entry, with bits [255:128] of the read bus driven to zero.
- R6: A read with view `00` returns bits [63:0] of the entry, with bits [255:64] of the read bus driven to zero.
- R7: A write with view code `11` is ignored: no bit of any entry changes.
- R8: A read whose index equals the index of a legal write in the same cycle returns the merged value. The written bits take the new data and the other bits keep the stored data. This applies on both read ports.
- R9: With `wr_en` low, no entry changes, whatever the other write inputs carry.
- R10: A read with view code `11` returns all zeros.
- R11: The two read ports work independently. Each returns its own index and view in the same cycle, including register indices 0 and 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears every entry |
| wr_en | input | 1 | Write request |
| wr_view | input | 2 | Write view code (00=64, 01=128, 10=256, 11=illegal) |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 256 | Write data; only the view's low bits are used |
| rd0_view | input | 2 | Read port 0 view code |
| rd0_idx | input | 5 | Read port 0 register index |
| rd0_data | output | 256 | Read port 0 data, zero-extended |
| rd1_view | input | 2 | Read port 1 view code |
| rd1_idx | input | 5 | Read port 1 register index |
| rd1_data | output | 256 | Read port 1 data, zero-extended |

## Verification
The directed part fills one entry with a full-width pattern, then overwrites it through the 128-bit view and then through the 64-bit view. Reading it back at full width shows whether the upper slices survived each narrow write. It also exercises the illegal write code and a write with enable low, both of which would corrupt a known pattern if acted on. In same-cycle bypass cases, both read ports target the written index with different views, which separates write-first merging from stale reads and from merges that clobber whole entries. Random cycles mix every view code on all three ports over a few hot indices, so collisions between read and write indices are frequent. This exposes errors in slice boundaries, in zero-extension and in port crosstalk.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

  typedef enum logic [1:0] {
    VIEW_S64  = 2'b00,
    VIEW_V128 = 2'b01,
    VIEW_V256 = 2'b10,
    VIEW_BAD  = 2'b11
  } view_e;

  // Storage is cut into nested slices: [S64) , [S64,V128) , [V128,V256)
  localparam int unsigned NUM_SLICE = 3;

  // A slice s is covered by a view when the view is legal and its
  // nesting level is at least s.
  function automatic logic slice_covered(input view_e v, input int unsigned s);
    logic res;
    res = (v != VIEW_BAD) && (int'(v) >= int'(s));
    return res;
  endfunction

endpackage

// File: rtl/vrf_wr_decode.sv
module vrf_wr_decode
  import vrf_pkg::*;
#(
  parameter int unsigned NREG  = 32,
  parameter int unsigned IDX_W = $clog2(NREG)
) (
  input  logic                 wr_en,
  input  logic [1:0]           wr_view,
  input  logic [IDX_W-1:0]     wr_idx,
  output logic [NREG-1:0]      row_sel,
  output logic [NUM_SLICE-1:0] slice_en
);

  view_e view_q;
  logic  legal;

  assign view_q = view_e'(wr_view);
  assign legal  = wr_en && (view_q != VIEW_BAD);

  for (genvar r = 0; r < NREG; r++) begin : g_row
    assign row_sel[r] = legal && (wr_idx == IDX_W'(r));
  end

  for (genvar s = 0; s < NUM_SLICE; s++) begin : g_slice
    assign slice_en[s] = legal && slice_covered(view_q, s);
  end

endmodule

// File: rtl/vrf_bank.sv
module vrf_bank
  import vrf_pkg::*;
#(
  parameter int unsigned NREG     = 32,
  parameter int unsigned NARROW_W = 64,
  parameter int unsigned MID_W    = 128,
  parameter int unsigned WIDE_W   = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NREG-1:0]      row_sel,
  input  logic [NUM_SLICE-1:0] slice_en,
  input  logic [WIDE_W-1:0]    wr_data,
  output logic [WIDE_W-1:0]    rows [NREG]
);

  for (genvar r = 0; r < NREG; r++) begin : g_row
    for (genvar s = 0; s < NUM_SLICE; s++) begin : g_slice
      localparam int unsigned LO = (s == 0) ? 0 : (s == 1) ? NARROW_W : MID_W;
      localparam int unsigned HI = (s == 0) ? NARROW_W - 1 :
                                   (s == 1) ? MID_W - 1 : WIDE_W - 1;
      localparam int unsigned SW = HI - LO + 1;

      logic [SW-1:0] slice_q;
      logic [SW-1:0] slice_d;
      logic          slice_ce;

      always_comb begin
        slice_ce = row_sel[r] && slice_en[s];
        slice_d  = wr_data[HI:LO];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slice_q <= '0;
        end else if (slice_ce) begin
          slice_q <= slice_d;
        end
      end

      assign rows[r][HI:LO] = slice_q;
    end
  end

endmodule

// File: rtl/vrf_rd_port.sv
module vrf_rd_port
  import vrf_pkg::*;
#(
  parameter int unsigned NREG     = 32,
  parameter int unsigned NARROW_W = 64,
  parameter int unsigned MID_W    = 128,
  parameter int unsigned WIDE_W   = 256,
  parameter int unsigned IDX_W    = $clog2(NREG)
) (
  input  logic [WIDE_W-1:0]    rows [NREG],
  input  logic [IDX_W-1:0]     rd_idx,
  input  logic [1:0]           rd_view,
  input  logic [NREG-1:0]      wr_row_sel,
  input  logic [NUM_SLICE-1:0] wr_slice_en,
  input  logic [WIDE_W-1:0]    wr_data,
  output logic [WIDE_W-1:0]    rd_data
);

  logic [WIDE_W-1:0] stored;
  logic              hit;
  view_e             view_q;

  assign stored = rows[rd_idx];
  assign hit    = wr_row_sel[rd_idx];
  assign view_q = view_e'(rd_view);

  for (genvar s = 0; s < NUM_SLICE; s++) begin : g_slice
    localparam int unsigned LO = (s == 0) ? 0 : (s == 1) ? NARROW_W : MID_W;
    localparam int unsigned HI = (s == 0) ? NARROW_W - 1 :
                                 (s == 1) ? MID_W - 1 : WIDE_W - 1;

    logic [HI-LO:0] merged;

    always_comb begin
      if (hit && wr_slice_en[s]) begin
        merged = wr_data[HI:LO];
      end else begin
        merged = stored[HI:LO];
      end
    end

    assign rd_data[HI:LO] = slice_covered(view_q, s) ? merged : '0;
  end

endmodule

// File: rtl/vrf_alias_top.sv
module vrf_alias_top
  import vrf_pkg::*;
#(
  parameter int unsigned NREG     = 32,
  parameter int unsigned NARROW_W = 64,
  parameter int unsigned MID_W    = 128,
  parameter int unsigned WIDE_W   = 256,
  parameter int unsigned NRD      = 2,
  parameter int unsigned IDX_W    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_view,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WIDE_W-1:0] wr_data,
  input  logic [1:0]        rd0_view,
  input  logic [IDX_W-1:0]  rd0_idx,
  output logic [WIDE_W-1:0] rd0_data,
  input  logic [1:0]        rd1_view,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic [WIDE_W-1:0] rd1_data
);

  logic [NREG-1:0]      row_sel;
  logic [NUM_SLICE-1:0] slice_en;
  logic [WIDE_W-1:0]    rows   [NREG];
  logic [1:0]           p_view [NRD];
  logic [IDX_W-1:0]     p_idx  [NRD];
  logic [WIDE_W-1:0]    p_data [NRD];

  vrf_wr_decode #(.NREG(NREG), .IDX_W(IDX_W)) u_dec (
    .wr_en    (wr_en),
    .wr_view  (wr_view),
    .wr_idx   (wr_idx),
    .row_sel  (row_sel),
    .slice_en (slice_en)
  );

  vrf_bank #(
    .NREG(NREG), .NARROW_W(NARROW_W), .MID_W(MID_W), .WIDE_W(WIDE_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .row_sel  (row_sel),
    .slice_en (slice_en),
    .wr_data  (wr_data),
    .rows     (rows)
  );

  assign p_view[0] = rd0_view;
  assign p_idx[0]  = rd0_idx;
  assign p_view[1] = rd1_view;
  assign p_idx[1]  = rd1_idx;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    vrf_rd_port #(
      .NREG(NREG), .NARROW_W(NARROW_W), .MID_W(MID_W), .WIDE_W(WIDE_W),
      .IDX_W(IDX_W)
    ) u_port (
      .rows        (rows),
      .rd_idx      (p_idx[p]),
      .rd_view     (p_view[p]),
      .wr_row_sel  (row_sel),
      .wr_slice_en (slice_en),
      .wr_data     (wr_data),
      .rd_data     (p_data[p])
    );
  end

  assign rd0_data = p_data[0];
  assign rd1_data = p_data[1];

endmodule

// File: rtl/vrf_alias_checker.sv
module vrf_alias_checker #(
  parameter int unsigned WIDE_W = 256,
  parameter int unsigned IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_view,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [WIDE_W-1:0] wr_data,
  input logic [1:0]        rd0_view,
  input logic [IDX_W-1:0]  rd0_idx,
  input logic [WIDE_W-1:0] rd0_data,
  input logic [1:0]        rd1_view,
  input logic [WIDE_W-1:0] rd1_data
);

  logic same_wr0;
  assign same_wr0 = wr_en && (wr_idx == rd0_idx);

  // R8: full-width same-cycle write is seen at once on port 0
  p_bypass_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (same_wr0 && wr_view == 2'b10 && rd0_view == 2'b10) |-> rd0_data == wr_data);

  // R6: 64-bit view reads zero-extend
  p_zext_s64_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_view == 2'b00) |-> rd1_data[WIDE_W-1:64] == '0);

  // R5: 128-bit view reads zero-extend
  p_zext_v128_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_view == 2'b01) |-> rd0_data[WIDE_W-1:128] == '0);

  // R10: illegal read view gives zeros
  p_bad_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_view == 2'b11) |-> rd0_data == '0);

  // R7: an illegal-view write leaves the entry unchanged
  p_bad_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(same_wr0 && wr_view == 2'b11 && rd0_view == 2'b10) &&
     $stable(rd0_idx) && rd0_view == 2'b10 && !same_wr0) |-> $stable(rd0_data));

  // R4: a 64-bit write keeps the upper bits
  p_keep_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(same_wr0 && wr_view == 2'b00 && rd0_view == 2'b10) &&
     $stable(rd0_idx) && rd0_view == 2'b10 && !same_wr0)
    |-> rd0_data[WIDE_W-1:64] == $past(rd0_data[WIDE_W-1:64]));

endmodule

bind vrf_alias_top vrf_alias_checker #(.WIDE_W(WIDE_W), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_view  (wr_view),
  .wr_idx   (wr_idx),
  .wr_data  (wr_data),
  .rd0_view (rd0_view),
  .rd0_idx  (rd0_idx),
  .rd0_data (rd0_data),
  .rd1_view (rd1_view),
  .rd1_data (rd1_data)
);

// File: tb/sim_vrf_alias_top.sv
module sim_vrf_alias_top;

  logic         clk;
  logic         rst_n;
  logic         wr_en;
  logic [1:0]   wr_view;
  logic [4:0]   wr_idx;
  logic [255:0] wr_data;
  logic [1:0]   rd0_view;
  logic [4:0]   rd0_idx;
  logic [255:0] rd0_data;
  logic [1:0]   rd1_view;
  logic [4:0]   rd1_idx;
  logic [255:0] rd1_data;

  logic [255:0] mdl [32];
  int n_chk;
  int n_err;
  bit done;

  vrf_alias_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_view(wr_view),
    .wr_idx(wr_idx), .wr_data(wr_data),
    .rd0_view(rd0_view), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
    .rd1_view(rd1_view), .rd1_idx(rd1_idx), .rd1_data(rd1_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [255:0] vmask(input logic [1:0] v);
    case (v)
      2'b00:   return {192'd0, {64{1'b1}}};
      2'b01:   return {128'd0, {128{1'b1}}};
      2'b10:   return {256{1'b1}};
      default: return '0;
    endcase
  endfunction

  function automatic logic [255:0] merge(input logic [255:0] old,
                                         input logic [255:0] d,
                                         input logic [1:0] v);
    logic [255:0] m;
    m = vmask(v);
    return (old & ~m) | (d & m);
  endfunction

  function automatic logic [255:0] expect_rd(input logic [4:0] i, input logic [1:0] v);
    logic [255:0] val;
    val = mdl[i];
    if (wr_en && wr_view != 2'b11 && wr_idx == i) val = merge(val, wr_data, wr_view);
    return val & vmask(v);
  endfunction

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom,
            $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at negedge, check combinational reads, then commit at posedge.
  task automatic step(input logic we, input logic [1:0] wv, input logic [4:0] wi,
                      input logic [255:0] wd, input logic [1:0] v0, input logic [4:0] i0,
                      input logic [1:0] v1, input logic [4:0] i1, input string tag);
    wr_en = we; wr_view = wv; wr_idx = wi; wr_data = wd;
    rd0_view = v0; rd0_idx = i0; rd1_view = v1; rd1_idx = i1;
    #1;
    check({tag, " port0"}, rd0_data, expect_rd(i0, v0));
    check({tag, " port1"}, rd1_data, expect_rd(i1, v1));
    @(posedge clk);
    if (we && wv != 2'b11) mdl[wi] = merge(mdl[wi], wd, wv);
    @(negedge clk);
  endtask

  initial begin
    logic [255:0] pa;
    logic [255:0] pb;
    void'($urandom(32'd4242));
    n_chk = 0; n_err = 0; done = 1'b0;
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    rst_n = 1'b0; wr_en = 1'b0; wr_view = 2'b10; wr_idx = '0; wr_data = '0;
    rd0_view = 2'b10; rd0_idx = '0; rd1_view = 2'b10; rd1_idx = 5'd31;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: all entries zero after reset
    for (int i = 0; i < 32; i += 2)
      step(1'b0, 2'b10, 5'd0, '0, 2'b10, 5'(i), 2'b10, 5'(i + 1), "R1 reset");

    pa = rnd256();
    pb = rnd256();
    // R2: full write and read back
    step(1'b1, 2'b10, 5'd5, pa, 2'b10, 5'd0, 2'b10, 5'd31, "R2 write");
    step(1'b0, 2'b10, 5'd0, '0, 2'b10, 5'd5, 2'b10, 5'd5, "R2 readback");
    // R3: 128-bit write keeps upper half
    step(1'b1, 2'b01, 5'd5, pb, 2'b10, 5'd1, 2'b10, 5'd2, "R3 write");
    step(1'b0, 2'b01, 5'd5, '0, 2'b10, 5'd5, 2'b01, 5'd5, "R3 readback");
    // R4: 64-bit write keeps upper bits
    step(1'b1, 2'b00, 5'd5, ~pa, 2'b10, 5'd1, 2'b10, 5'd2, "R4 write");
    step(1'b0, 2'b00, 5'd5, '0, 2'b10, 5'd5, 2'b00, 5'd5, "R4/R6 readback");
    // R5/R10 view shaping
    step(1'b0, 2'b00, 5'd5, '0, 2'b01, 5'd5, 2'b11, 5'd5, "R5/R10 views");
    // R7: illegal write ignored
    step(1'b1, 2'b11, 5'd5, pb, 2'b10, 5'd5, 2'b10, 5'd5, "R7 write");
    step(1'b0, 2'b10, 5'd5, '0, 2'b10, 5'd5, 2'b00, 5'd5, "R7 readback");
    // R9: write disabled
    step(1'b0, 2'b10, 5'd5, pa, 2'b10, 5'd5, 2'b10, 5'd5, "R9 disabled");
    step(1'b0, 2'b10, 5'd5, '0, 2'b10, 5'd5, 2'b01, 5'd5, "R9 readback");
    // R8: same-cycle bypass with partial merge on both ports
    step(1'b1, 2'b10, 5'd31, pa, 2'b10, 5'd31, 2'b00, 5'd31, "R8 full bypass");
    step(1'b1, 2'b00, 5'd31, pb, 2'b10, 5'd31, 2'b01, 5'd31, "R8 s64 bypass");
    step(1'b1, 2'b01, 5'd0, pb, 2'b10, 5'd0, 2'b10, 5'd31, "R8 v128 bypass");
    // R11: independent ports at boundary indices
    step(1'b0, 2'b10, 5'd0, '0, 2'b10, 5'd0, 2'b10, 5'd31, "R11 idx0/31");
    step(1'b0, 2'b10, 5'd0, '0, 2'b00, 5'd31, 2'b01, 5'd0, "R11 mixed views");

    // Random phase on a few hot indices
    for (int k = 0; k < 3000; k++) begin
      logic [4:0] wi;
      wi = ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % 4);
      step(1'($urandom % 4 != 0), 2'($urandom), wi, rnd256(),
           2'($urandom), 5'($urandom % 4), 2'($urandom), 5'($urandom % 4),
           "R11 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule